// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Per-Word Presence Bits

This block is a 1 KB direct-mapped data cache. It has 32 lines of 32 bytes and sits between a processor and a slower lower-level memory. The processor issues single-word reads and byte-enabled writes over a valid/ready request channel. Read data comes back over a valid/ready response channel. A line that the cache does not hold is fetched over a request channel to memory and returned as eight word beats on a memory response channel.

Each line stores a tag, a dirty flag and one presence bit for each 4-byte word. A write that misses does not fetch from memory. It claims the line for the new tag, clears every presence bit, stores the enabled bytes and marks only the touched word present. A later read hits only when the tag matches and the addressed word is present. If the tag matches but the word is absent, the whole line is fetched. Words already present keep their cached contents, the rest are filled from memory, and the line then becomes fully present.

Back-pressure works as follows:
- The request channel accepts one request at a time.
- `req_ready` stays low from the acceptance of a read until its response has been taken.
- A read response is held, unchanged, until `rsp_ready` is seen.
- A memory request is held, unchanged, until `mem_req_ready` is seen.
- Fill beats are consumed only on cycles where `mem_rsp_valid` is high, so the memory may leave gaps between beats.
- Writes complete in the cycle they are accepted and produce no response.
- Dirty lines are not written back. A replaced line's contents are dropped, because forwarding them belongs to a separate block.

Top module: `sbv_dcache`

## Requirements
- R1: Address bits [4:2] select the word within a line, bits [9:5] select the line and bits [31:10] form the tag. A line fetch is requested at the byte address with bits [4:0] cleared.
- R2: After reset no line holds anything. `req_ready` is high, `rsp_valid`, `mem_req_valid` and `mem_rsp_ready` are low, and the first read of any address requests a line from memory.
- R3: A read hit raises `rsp_valid` one cycle after acceptance and issues no memory request. While `rsp_valid` is high and `rsp_ready` is low, the data and dirty outputs stay stable and `req_ready` stays low.
- R4: A read miss issues one line request and then takes eight beats, word 0 first and word 7 last. `rsp_valid` rises in the cycle after the last beat, carrying the requested word, and any word of that line then hits.
- R5: A write hit changes only the bytes whose enable bit is set (`req_be[i]` covers bits 8i+7..8i) and sets the line's dirty flag, which a later read reports on `rsp_dirty`.
- R6: A write miss is accepted in one cycle without a memory request or a response. It installs the new tag, stores the enabled bytes and marks only the written word present. A 16-bit write at the start of a line therefore leaves the other words absent.
- R7: A read whose tag matches but whose word is absent fetches the line. Present words keep their cached data, absent words take memory data, the dirty flag is kept, and all words are present afterwards.
- R8: A read miss with a different tag replaces the line. Earlier writes to it are discarded and the reported dirty flag is 0.
- R9: `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready` is seen. Fill beats are taken only when `mem_rsp_valid` is high, and idle cycles between beats are allowed.
- R10: A write with all byte enables low changes no data, presence or dirty state.
- R11: Two addresses with the same line index and different tags displace each other, so a read of the first one after the second has been loaded fetches again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Processor takes the read data |
| rsp_rdata | output | 32 | Read data word |
| rsp_dirty | output | 1 | Dirty flag of the line that served the read |
| mem_req_valid | output | 1 | Line fetch request |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_req_addr | output | 32 | Line-aligned fetch address |
| mem_rsp_valid | input | 1 | Fill beat present |
| mem_rsp_ready | output | 1 | Cache takes a fill beat |
| mem_rsp_data | input | 32 | Fill beat data |

## Verification
The lookup is driven with several patterns, each of which separates one outcome from another:
- A cold read, then a read of another word of the same line, separate a fetch from a hit.
- Byte-masked writes to a resident line separate a byte merge from a whole-word overwrite.
- A full-word write miss followed by a read of a neighbouring word separates presence per word from presence per line.
- The fill that follows that read separates keeping cached words from overwriting them.
- A competing tag at the same index separates replacement from a false hit.
- A write with all enables low shows whether an empty enable mask is a no-op or clobbers the line.
- A read with delayed memory acceptance, gaps between fill beats and a stalled response exercises every back-pressure point.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MREQ = 2'd1,
    ST_FILL = 2'd2,
    ST_RESP = 2'd3
  } dc_state_e;
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int LINES = 32,
  parameter int IDX_W = 5,
  parameter int TAG_W = 22,
  parameter int SUBS  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic [SUBS-1:0]  rd_valid,
  output logic             rd_dirty,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [SUBS-1:0]  wr_valid,
  input  logic             wr_dirty
);
  logic [TAG_W-1:0] tag_q   [LINES];
  logic [SUBS-1:0]  valid_q [LINES];
  logic             dirty_q [LINES];

  // presence and dirty state are cleared on reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        valid_q[i] <= '0;
        dirty_q[i] <= 1'b0;
      end
    end else if (wr_en) begin
      valid_q[wr_idx] <= wr_valid;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  // tags carry no reset: they are meaningless while no word is present
  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_tag   = tag_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
  parameter int LINES      = 32,
  parameter int IDX_W      = 5,
  parameter int WORDS      = 8,
  parameter int WSEL_W     = 3,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic [IDX_W-1:0]        rd_idx,
  input  logic [WSEL_W-1:0]       rd_word,
  output logic [WORD_BYTES*8-1:0] rd_data,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [WSEL_W-1:0]       wr_word,
  input  logic [WORD_BYTES-1:0]   wr_be,
  input  logic [WORD_BYTES*8-1:0] wr_data
);
  localparam int ENTRIES = LINES * WORDS;
  localparam int ENT_W   = IDX_W + WSEL_W;

  logic [ENT_W-1:0] rd_ent;
  logic [ENT_W-1:0] wr_ent;

  assign rd_ent = {rd_idx, rd_word};
  assign wr_ent = {wr_idx, wr_word};

  // one independent storage lane per byte of the word
  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
    logic [7:0] lane_q [ENTRIES];

    always_ff @(posedge clk) begin
      if (wr_en && wr_be[b]) lane_q[wr_ent] <= wr_data[b*8 +: 8];
    end

    assign rd_data[b*8 +: 8] = lane_q[rd_ent];
  end
endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 5,
  parameter int TAG_W      = 22,
  parameter int OFF_W      = 5,
  parameter int WSEL_W     = 3,
  parameter int BSEL_W     = 2,
  parameter int SUBS       = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  // processor side
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [WORD_BYTES-1:0]   req_be,
  input  logic [WORD_BYTES*8-1:0] req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [WORD_BYTES*8-1:0] rsp_rdata,
  output logic                    rsp_dirty,
  // memory side
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [ADDR_W-1:0]       mem_req_addr,
  input  logic                    mem_rsp_valid,
  output logic                    mem_rsp_ready,
  input  logic [WORD_BYTES*8-1:0] mem_rsp_data,
  // tag store
  output logic [IDX_W-1:0]        tg_idx,
  input  logic [TAG_W-1:0]        tg_tag,
  input  logic [SUBS-1:0]         tg_valid,
  input  logic                    tg_dirty,
  output logic                    tg_we,
  output logic [TAG_W-1:0]        tg_wtag,
  output logic [SUBS-1:0]         tg_wvalid,
  output logic                    tg_wdirty,
  // data store
  output logic [WSEL_W-1:0]       dt_rword,
  input  logic [WORD_BYTES*8-1:0] dt_rdata,
  output logic                    dt_we,
  output logic [WSEL_W-1:0]       dt_wword,
  output logic [WORD_BYTES-1:0]   dt_be,
  output logic [WORD_BYTES*8-1:0] dt_wdata
);
  localparam int DATA_W = WORD_BYTES * 8;

  dc_state_e                state_q;
  logic [ADDR_W-1:0]        addr_q;
  logic [SUBS-1:0]          keep_q;
  logic                     keep_dirty_q;
  logic [WSEL_W-1:0]        beat_q;
  logic [DATA_W-1:0]        rdata_q;
  logic                     rdirty_q;

  logic [ADDR_W-1:0]        look_addr;
  logic [TAG_W-1:0]         look_tag;
  logic [WSEL_W-1:0]        look_word;
  logic                     tag_match;
  logic                     word_hit;
  logic                     accept;
  logic                     last_beat;
  logic [SUBS-1:0]          touch;
  logic                     unused_low;

  // the lookup follows the incoming request while idle, the held one otherwise
  assign look_addr = (state_q == ST_IDLE) ? req_addr : addr_q;
  assign look_tag  = look_addr[ADDR_W-1 -: TAG_W];
  assign look_word = look_addr[BSEL_W +: WSEL_W];
  assign unused_low = ^look_addr[BSEL_W-1:0];

  assign tg_idx    = look_addr[OFF_W +: IDX_W];
  assign tag_match = (|tg_valid) && (tg_tag == look_tag);
  assign word_hit  = tag_match && tg_valid[look_word];
  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign last_beat = (beat_q == WSEL_W'(SUBS - 1));
  assign touch     = SUBS'(1) << look_word;

  assign dt_rword  = (state_q == ST_FILL) ? beat_q : look_word;

  always_comb begin
    tg_we     = 1'b0;
    tg_wtag   = look_tag;
    tg_wvalid = tg_valid;
    tg_wdirty = tg_dirty;
    dt_we     = 1'b0;
    dt_wword  = look_word;
    dt_be     = '0;
    dt_wdata  = req_wdata;
    if (accept && req_write && (|req_be)) begin
      // hit keeps the present words, miss starts the line afresh
      tg_we     = 1'b1;
      tg_wvalid = (tag_match ? tg_valid : '0) | touch;
      tg_wdirty = 1'b1;
      dt_we     = 1'b1;
      dt_be     = req_be;
    end else if ((state_q == ST_FILL) && mem_rsp_valid) begin
      dt_we    = 1'b1;
      dt_wword = beat_q;
      dt_be    = keep_q[beat_q] ? '0 : '1;
      dt_wdata = mem_rsp_data;
      if (last_beat) begin
        tg_we     = 1'b1;
        tg_wvalid = '1;
        tg_wdirty = keep_dirty_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      keep_q       <= '0;
      keep_dirty_q <= 1'b0;
      beat_q       <= '0;
      rdata_q      <= '0;
      rdirty_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q <= req_addr;
            if (!req_write) begin
              if (word_hit) begin
                rdata_q  <= dt_rdata;
                rdirty_q <= tg_dirty;
                state_q  <= ST_RESP;
              end else begin
                keep_q       <= tag_match ? tg_valid : '0;
                keep_dirty_q <= tag_match && tg_dirty;
                state_q      <= ST_MREQ;
              end
            end
          end
        end
        ST_MREQ: begin
          if (mem_req_ready) begin
            beat_q  <= '0;
            state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_rsp_valid) begin
            beat_q <= beat_q + WSEL_W'(1);
            if (beat_q == look_word) begin
              rdata_q <= keep_q[beat_q] ? dt_rdata : mem_rsp_data;
            end
            if (last_beat) begin
              rdirty_q <= keep_dirty_q;
              state_q  <= ST_RESP;
            end
          end
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_rdata     = rdata_q;
  assign rsp_dirty     = rdirty_q;
  assign mem_req_valid = (state_q == ST_MREQ);
  assign mem_req_addr  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_rsp_ready = (state_q == ST_FILL);
endmodule

// File: rtl/sbv_dcache.sv
module sbv_dcache #(
  parameter int ADDR_W     = 32,
  parameter int LINES      = 32,
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [WORD_BYTES-1:0]   req_be,
  input  logic [WORD_BYTES*8-1:0] req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [WORD_BYTES*8-1:0] rsp_rdata,
  output logic                    rsp_dirty,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [ADDR_W-1:0]       mem_req_addr,
  input  logic                    mem_rsp_valid,
  output logic                    mem_rsp_ready,
  input  logic [WORD_BYTES*8-1:0] mem_rsp_data
);
  localparam int DATA_W = WORD_BYTES * 8;
  localparam int WORDS  = LINE_BYTES / WORD_BYTES;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int BSEL_W = $clog2(WORD_BYTES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

  logic [IDX_W-1:0]  tg_idx;
  logic [TAG_W-1:0]  tg_tag;
  logic [WORDS-1:0]  tg_valid;
  logic              tg_dirty;
  logic              tg_we;
  logic [TAG_W-1:0]  tg_wtag;
  logic [WORDS-1:0]  tg_wvalid;
  logic              tg_wdirty;
  logic [WSEL_W-1:0] dt_rword;
  logic [DATA_W-1:0] dt_rdata;
  logic              dt_we;
  logic [WSEL_W-1:0] dt_wword;
  logic [WORD_BYTES-1:0] dt_be;
  logic [DATA_W-1:0] dt_wdata;

  dc_ctrl #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W),
    .WSEL_W(WSEL_W), .BSEL_W(BSEL_W), .SUBS(WORDS), .WORD_BYTES(WORD_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_dirty(rsp_dirty),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .tg_idx(tg_idx), .tg_tag(tg_tag), .tg_valid(tg_valid), .tg_dirty(tg_dirty),
    .tg_we(tg_we), .tg_wtag(tg_wtag), .tg_wvalid(tg_wvalid), .tg_wdirty(tg_wdirty),
    .dt_rword(dt_rword), .dt_rdata(dt_rdata), .dt_we(dt_we),
    .dt_wword(dt_wword), .dt_be(dt_be), .dt_wdata(dt_wdata)
  );

  dc_tag_store #(
    .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .SUBS(WORDS)
  ) u_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(tg_idx), .rd_tag(tg_tag), .rd_valid(tg_valid), .rd_dirty(tg_dirty),
    .wr_en(tg_we), .wr_idx(tg_idx), .wr_tag(tg_wtag),
    .wr_valid(tg_wvalid), .wr_dirty(tg_wdirty)
  );

  dc_data_store #(
    .LINES(LINES), .IDX_W(IDX_W), .WORDS(WORDS), .WSEL_W(WSEL_W),
    .WORD_BYTES(WORD_BYTES)
  ) u_data (
    .clk(clk),
    .rd_idx(tg_idx), .rd_word(dt_rword), .rd_data(dt_rdata),
    .wr_en(dt_we), .wr_idx(tg_idx), .wr_word(dt_wword),
    .wr_be(dt_be), .wr_data(dt_wdata)
  );
endmodule

// File: rtl/dc_chk.sv
module dc_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_dirty,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr
);
  // R3
  resp_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R3
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_dirty)));

  // R9
  mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R1
  mreq_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));

  // R6
  write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> (!rsp_valid && !mem_req_valid));
endmodule

bind sbv_dcache dc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .rsp_dirty(rsp_dirty), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr)
);

// File: tb/sbv_dcache_tb.sv
module sbv_dcache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;
  logic        rsp_dirty;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sbv_dcache u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_dirty(rsp_dirty),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data)
  );

  // lower-level memory content: upper half = address, lower half = its inverse
  function automatic logic [31:0] memfn(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [31:0] a, input logic [3:0] be,
                           input logic [31:0] d, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check(!rsp_valid && !mem_req_valid, req, "write drew response or fetch",
          {30'd0, rsp_valid, mem_req_valid}, 32'd0);
  endtask

  task automatic cpu_read(input logic [31:0] a, input int mem_delay, input int beat_gap,
                          input int stall, input string req,
                          output logic [31:0] data, output logic dirty,
                          output logic fetched);
    logic [31:0] maddr;
    logic [31:0] held;
    fetched = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = '0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!rsp_valid && !mem_req_valid) begin
      check(1'b0, req, "neither response nor fetch after accept", 32'd0, 32'd1);
    end
    if (mem_req_valid) begin
      fetched = 1'b1;
      maddr = mem_req_addr;
      // R1: fetch address is the line base
      check(maddr == {a[31:5], 5'd0}, "R1", "fetch address", maddr, {a[31:5], 5'd0});
      for (int w = 0; w < mem_delay; w++) begin
        @(negedge clk);
        // R9: request held while memory stalls
        check(mem_req_valid && mem_req_addr == maddr, "R9", "request held",
              mem_req_addr, maddr);
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      for (int k = 0; k < 8; k++) begin
        for (int g = 0; g < beat_gap; g++) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = memfn({maddr[31:5], 3'(k), 2'b00});
        if (!mem_rsp_ready) check(1'b0, "R4", "fill beat not taken", 32'd0, 32'd1);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
      // R4: response in the cycle after the last beat
      check(rsp_valid, "R4", "response after last beat", {31'd0, rsp_valid}, 32'd1);
    end
    held = rsp_rdata;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      // R3: response held while stalled, no new request accepted
      check(rsp_valid && !req_ready && rsp_rdata == held, "R3", "stalled response held",
            rsp_rdata, held);
    end
    data  = rsp_rdata;
    dirty = rsp_dirty;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(!rsp_valid && req_ready, "R3", "response retired",
          {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [31:0] mask;
    logic        fetch;
    logic        dirty;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VEC [NVEC] = '{
    // R4 cold read, R2 first read fetches
    '{1'b0, 32'h0000_1060, 4'h0, 32'h0, 32'h1060_EF9F, 32'hFFFF_FFFF, 1'b1, 1'b0, 8'd4},
    // R4 other word of a filled line hits
    '{1'b0, 32'h0000_1068, 4'h0, 32'h0, 32'h1068_EF97, 32'hFFFF_FFFF, 1'b0, 1'b0, 8'd4},
    // R5 byte-masked write hit
    '{1'b1, 32'h0000_1064, 4'h3, 32'h0000_BEEF, 32'h0, 32'h0, 1'b0, 1'b0, 8'd5},
    '{1'b0, 32'h0000_1064, 4'h0, 32'h0, 32'h1064_BEEF, 32'hFFFF_FFFF, 1'b0, 1'b1, 8'd5},
    // R6 full-word write miss, same index, new tag
    '{1'b1, 32'h0000_2064, 4'hF, 32'hCAFE_F00D, 32'h0, 32'h0, 1'b0, 1'b0, 8'd6},
    '{1'b0, 32'h0000_2064, 4'h0, 32'h0, 32'hCAFE_F00D, 32'hFFFF_FFFF, 1'b0, 1'b1, 8'd6},
    // R7 tag match, absent word: fetch and merge, dirty kept
    '{1'b0, 32'h0000_2068, 4'h0, 32'h0, 32'h2068_DF97, 32'hFFFF_FFFF, 1'b1, 1'b1, 8'd7},
    '{1'b0, 32'h0000_2064, 4'h0, 32'h0, 32'hCAFE_F00D, 32'hFFFF_FFFF, 1'b0, 1'b1, 8'd7},
    // R8 replacement drops written data, dirty cleared
    '{1'b0, 32'h0000_1064, 4'h0, 32'h0, 32'h1064_EF9B, 32'hFFFF_FFFF, 1'b1, 1'b0, 8'd8},
    // R10 empty byte mask on a clean line
    '{1'b1, 32'h0000_1064, 4'h0, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0, 1'b0, 8'd10},
    '{1'b0, 32'h0000_1064, 4'h0, 32'h0, 32'h1064_EF9B, 32'hFFFF_FFFF, 1'b0, 1'b0, 8'd10},
    // R6 16-bit write miss into an empty line
    '{1'b1, 32'h0000_0044, 4'h3, 32'h0000_1234, 32'h0, 32'h0, 1'b0, 1'b0, 8'd6},
    '{1'b0, 32'h0000_0044, 4'h0, 32'h0, 32'h0000_1234, 32'h0000_FFFF, 1'b0, 1'b1, 8'd6},
    // R7 neighbouring word absent, then whole line present
    '{1'b0, 32'h0000_0048, 4'h0, 32'h0, 32'h0048_FFB7, 32'hFFFF_FFFF, 1'b1, 1'b1, 8'd7},
    '{1'b0, 32'h0000_0040, 4'h0, 32'h0, 32'h0040_FFBF, 32'hFFFF_FFFF, 1'b0, 1'b1, 8'd7},
    // R4 last word of a filled line hits
    '{1'b0, 32'h0000_107C, 4'h0, 32'h0, 32'h107C_EF83, 32'hFFFF_FFFF, 1'b0, 1'b0, 8'd4},
    // R1 top index, last word
    '{1'b0, 32'h0000_33FC, 4'h0, 32'h0, 32'h33FC_CC03, 32'hFFFF_FFFF, 1'b1, 1'b0, 8'd1},
    // R11 evicted tag fetches again
    '{1'b0, 32'h0000_2064, 4'h0, 32'h0, 32'h2064_DF9B, 32'hFFFF_FFFF, 1'b1, 1'b0, 8'd11}
  };

  initial begin
    for (int c = 0; c < 50000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        dy;
    logic        f;
    string       tag;

    repeat (3) @(negedge clk);
    // R2 reset state
    check(req_ready && !rsp_valid && !mem_req_valid && !mem_rsp_ready, "R2", "reset outputs",
          {28'd0, req_ready, rsp_valid, mem_req_valid, mem_rsp_ready}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      tag = $sformatf("R%0d", VEC[i].req);
      if (VEC[i].wr) begin
        cpu_write(VEC[i].addr, VEC[i].be, VEC[i].wdata, tag);
      end else begin
        cpu_read(VEC[i].addr, 0, 0, 0, tag, d, dy, f);
        check((d & VEC[i].mask) == (VEC[i].exp & VEC[i].mask), tag, "read data",
              d & VEC[i].mask, VEC[i].exp & VEC[i].mask);
        check(f == VEC[i].fetch, tag, "fetch issued", {31'd0, f}, {31'd0, VEC[i].fetch});
        check(dy == VEC[i].dirty, tag, "dirty flag", {31'd0, dy}, {31'd0, VEC[i].dirty});
      end
    end

    // R9 memory back-pressure and gapped beats, R3 stalled response
    cpu_read(32'h0000_5000, 3, 2, 3, "R9", d, dy, f);
    check(d == 32'h5000_AFFF && f, "R9", "gapped fill data", d, 32'h5000_AFFF);

    // R2 reset in mid-run forgets resident lines
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req_valid, "R2", "outputs in reset",
          {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'h4);
    rst_n = 1'b1;
    cpu_read(32'h0000_1068, 0, 0, 0, "R2", d, dy, f);
    check(f, "R2", "resident line fetched again after reset", {31'd0, f}, 32'd1);
    check(d == 32'h1068_EF97, "R2", "data after reset fetch", d, 32'h1068_EF97);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule